// File: doc/BRIEF.md
# Scalar Single-to-Double Widening Converter

This block turns one IEEE-754 single-precision number into the double-precision number of equal value and builds a whole vector-register result around it. The 64-bit converted value always lands in the lowest lane. The bits above it come from one of three places, chosen by a two-bit format select: the old destination, the first source vector, or zero. In the masked format, a one-bit write mask together with a merge/zero control decides whether the low lane takes the converted value, keeps its old contents or is cleared.

The conversion is exact. Normal numbers are rebiased. Subnormal numbers are normalised by a leading-zero count. Signalling NaNs are made quiet, and signed zeros and infinities keep their sign. Only two status flags exist: Invalid, for a signalling NaN input, and Denormal, for a subnormal input. The result and the flags pass through one register stage with a valid/ready handshake. A held result stays stable until the consumer accepts it.

Top module: `sp2dp_widen`

## Requirements
- R1: A normal single input (biased exponent 1..254) gives a double with the same sign, exponent plus 896, and the 23 fraction bits placed at the top of the 52-bit fraction with zeros below. No flag is raised.
- R2: A subnormal single input (exponent 0, fraction nonzero) gives the exactly equal normal double and raises flag_denorm.
- R3: A signalling NaN (exponent 255, fraction bit 22 clear, fraction nonzero) gives a double NaN with the same sign, fraction bit 51 set and the remaining 22 payload bits at fraction bits 50:29. It raises flag_invalid. A quiet NaN converts by the same placement and raises no flag.
- R4: Zeros and infinities of either sign convert to the double zero or infinity of the same sign, with no flag.
- R5: In legacy format (mode 2'b00), out_data bits VW-1:64 equal dst_old bits VW-1:64.
- R6: In VEX format (mode 2'b01), EVEX format (mode 2'b10) and the spare code 2'b11 (which behaves as VEX), out_data bits 127:64 equal src1 bits 127:64, and all bits from 128 upward are zero.
- R7: In EVEX format the low 64 bits take the converted value when mask_bit is 1 or mask_en is 0. Otherwise they keep dst_old[63:0] when zero_mask is 0, and they are cleared when zero_mask is 1. In both of those cases both flags are 0.
- R8: In legacy and VEX formats, mask_en, mask_bit and zero_mask have no effect on the output.
- R9: A result accepted on a clock edge appears on out_data with out_valid one edge later. It is held unchanged while out_valid is 1 and out_ready is 0. in_ready equals (not out_valid) or out_ready.
- R10: After a synchronous reset, out_valid, out_data and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| mode | input | 2 | Format: 00 legacy, 01 VEX, 10 EVEX, 11 as VEX |
| mask_en | input | 1 | A write mask applies (EVEX only) |
| mask_bit | input | 1 | Write-mask bit for the low lane |
| zero_mask | input | 1 | 1 clears, 0 merges, a masked-off low lane |
| dst_old | input | VW | Previous destination register contents |
| src1 | input | VW | First source vector |
| cvt_src | input | 32 | Convert-from operand, single value in bits 31:0 |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VW | New destination register contents |
| flag_invalid | output | 1 | Signalling NaN was converted |
| flag_denorm | output | 1 | Subnormal input was converted |

## Verification
The hardest state to reach from the ports is a stalled result stage that also has a new operation waiting at its input. On the edge the consumer releases the stall, the held result must leave and the waiting one must enter. The stimulus lowers out_ready, issues one conversion, and keeps a second, different one offered for several cycles. It checks that the first result and in_ready stay fixed. Then it raises out_ready and expects the second result on the next sampled half-cycle. Masked-off signalling NaNs in EVEX format are also driven, to show that suppression removes the Invalid flag as well as the data.

// File: rtl/fwiden_pkg.sv
package fwiden_pkg;
  localparam int SP_W    = 32;
  localparam int DP_W    = 64;
  localparam int SP_FRAC = 23;
  localparam int DP_FRAC = 52;
  localparam int DP_EXP  = 11;
  localparam int REBIAS  = 896;

  typedef enum logic [1:0] {
    FMT_LEGACY = 2'b00,
    FMT_VEX    = 2'b01,
    FMT_EVEX   = 2'b10,
    FMT_SPARE  = 2'b11
  } fw_fmt_e;

  typedef struct packed {
    logic [DP_W-1:0] bits;
    logic            invalid;
    logic            denorm;
  } fw_conv_t;
endpackage

// File: rtl/fwiden_lzc.sv
module fwiden_lzc #(
  parameter int W  = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fwiden_conv.sv
module fwiden_conv
  import fwiden_pkg::*;
(
  input  logic [SP_W-1:0] sp,
  output fw_conv_t        res
);
  localparam int LZW = $clog2(SP_FRAC + 1);

  logic               sgn;
  logic [7:0]         ex;
  logic [SP_FRAC-1:0] fr;
  logic [LZW-1:0]     lz;
  logic [SP_FRAC-1:0] fr_norm;
  logic [DP_EXP-1:0]  ex_sub;

  assign sgn = sp[31];
  assign ex  = sp[30:23];
  assign fr  = sp[22:0];

  fwiden_lzc #(.W(SP_FRAC)) u_lzc (.vec(fr), .zeros(lz));

  // Subnormal: drop the leading one after shifting it out of the field.
  assign fr_norm = fr << (lz + LZW'(1));
  assign ex_sub  = DP_EXP'(REBIAS) - DP_EXP'(lz);

  always_comb begin
    res = '0;
    if (ex == 8'hFF) begin
      if (fr == '0) begin
        res.bits = {sgn, 11'h7FF, 52'b0};
      end else begin
        res.bits    = {sgn, 11'h7FF, 1'b1, fr[21:0], 29'b0};
        res.invalid = ~fr[22];
      end
    end else if (ex == 8'h00) begin
      if (fr == '0) begin
        res.bits = {sgn, 63'b0};
      end else begin
        res.bits   = {sgn, ex_sub, fr_norm, 29'b0};
        res.denorm = 1'b1;
      end
    end else begin
      res.bits = {sgn, DP_EXP'(ex) + DP_EXP'(REBIAS), fr, 29'b0};
    end
  end
endmodule

// File: rtl/fwiden_lane.sv
module fwiden_lane
  import fwiden_pkg::*;
#(
  parameter int VW = 256
) (
  input  fw_fmt_e       fmt,
  input  logic          mask_en,
  input  logic          mask_bit,
  input  logic          zero_mask,
  input  logic [VW-1:0] dst_old,
  input  logic [VW-1:0] src1,
  input  fw_conv_t      conv,
  output logic [VW-1:0] data,
  output logic          invalid,
  output logic          denorm
);
  logic          wr_low;
  logic [VW-1:0] vex_img;

  assign wr_low = (fmt != FMT_EVEX) || !mask_en || mask_bit;

  always_comb begin
    vex_img         = '0;
    vex_img[127:64] = src1[127:64];
    data            = (fmt == FMT_LEGACY) ? dst_old : vex_img;
    if (wr_low)          data[63:0] = conv.bits;
    else if (zero_mask)  data[63:0] = '0;
    else                 data[63:0] = dst_old[63:0];
  end

  assign invalid = wr_low & conv.invalid;
  assign denorm  = wr_low & conv.denorm;
endmodule

// File: rtl/sp2dp_widen.sv
module sp2dp_widen
  import fwiden_pkg::*;
#(
  parameter int VW = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    mode,
  input  logic          mask_en,
  input  logic          mask_bit,
  input  logic          zero_mask,
  input  logic [VW-1:0] dst_old,
  input  logic [VW-1:0] src1,
  input  logic [31:0]   cvt_src,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_data,
  output logic          flag_invalid,
  output logic          flag_denorm
);
  fw_conv_t      conv;
  logic [VW-1:0] nxt_data;
  logic          nxt_inv, nxt_den, take;

  fwiden_conv u_conv (.sp(cvt_src), .res(conv));

  fwiden_lane #(.VW(VW)) u_lane (
    .fmt(fw_fmt_e'(mode)), .mask_en(mask_en), .mask_bit(mask_bit),
    .zero_mask(zero_mask), .dst_old(dst_old), .src1(src1), .conv(conv),
    .data(nxt_data), .invalid(nxt_inv), .denorm(nxt_den)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      flag_invalid <= 1'b0;
      flag_denorm  <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_data     <= nxt_data;
      flag_invalid <= nxt_inv;
      flag_denorm  <= nxt_den;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/sp2dp_widen_chk.sv
module sp2dp_widen_chk #(
  parameter int VW = 256
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    mode,
  input logic          mask_en,
  input logic          mask_bit,
  input logic          zero_mask,
  input logic [VW-1:0] dst_old,
  input logic [VW-1:0] src1,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_data,
  input logic          flag_invalid,
  input logic          flag_denorm
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable(flag_invalid) && $stable(flag_denorm)));

  assert_ready_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_legacy_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && mode == 2'b00) |=> out_data[VW-1:64] == $past(dst_old[VW-1:64]));

  assert_vex_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && mode != 2'b00) |=> out_data[127:64] == $past(src1[127:64]));

  generate
    if (VW > 128) begin : g_wide
      assert_vex_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && mode != 2'b00) |=> out_data[VW-1:128] == '0);
    end
  endgenerate

  assert_zero_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && mode == 2'b10 && mask_en && !mask_bit && zero_mask)
      |=> (out_data[63:0] == 64'b0 && !flag_invalid && !flag_denorm));

  assert_merge_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && mode == 2'b10 && mask_en && !mask_bit && !zero_mask)
      |=> out_data[63:0] == $past(dst_old[63:0]));
endmodule

bind sp2dp_widen sp2dp_widen_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .mode(mode), .mask_en(mask_en), .mask_bit(mask_bit),
  .zero_mask(zero_mask), .dst_old(dst_old), .src1(src1),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
);

// File: tb/tb_sp2dp_widen.sv
`timescale 1ns/1ps
module tb_sp2dp_widen;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    mode = 2'b00;
  logic          mask_en = 1'b0, mask_bit = 1'b0, zero_mask = 1'b0;
  logic [VW-1:0] dst_old = '0, src1 = '0;
  logic [31:0]   cvt_src = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_data;
  logic          flag_invalid, flag_denorm;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sp2dp_widen #(.VW(VW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .mask_en(mask_en), .mask_bit(mask_bit),
    .zero_mask(zero_mask), .dst_old(dst_old), .src1(src1),
    .cvt_src(cvt_src), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .flag_invalid(flag_invalid),
    .flag_denorm(flag_denorm)
  );

  localparam logic [VW-1:0] OLD_V = {4{64'hA5A5_0123_4567_89AB}};
  localparam logic [VW-1:0] S1_V  = {4{64'h1357_9BDF_2468_ACE0}};

  function automatic real pow2(int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r * 0.5;
    return r;
  endfunction

  // Independent model: value via real arithmetic, special cases by bits.
  function automatic logic [65:0] conv_model(logic [31:0] x);
    logic [63:0] b;
    logic inv = 1'b0, den = 1'b0;
    real r;
    if (x[30:23] == 8'hFF && x[22:0] != 0) begin
      b   = {x[31], 11'h7FF, 1'b1, x[21:0], 29'b0};
      inv = ~x[22];
    end else if (x[30:23] == 8'hFF) begin
      b = {x[31], 11'h7FF, 52'b0};
    end else if (x[30:0] == 0) begin
      b = {x[31], 63'b0};
    end else begin
      if (x[30:23] == 0) begin
        r   = real'(x[22:0]) * pow2(-149);
        den = 1'b1;
      end else begin
        r = (1.0 + real'(x[22:0]) / 8388608.0) * pow2(int'(x[30:23]) - 127);
      end
      b = $realtobits(r);
      b[63] = x[31];
    end
    return {inv, den, b};
  endfunction

  function automatic logic [VW+1:0] expect_out(logic [1:0] md, logic me,
      logic mb, logic zm, logic [VW-1:0] old, logic [VW-1:0] s1,
      logic [31:0] x);
    logic [65:0]   c = conv_model(x);
    logic [VW-1:0] d;
    logic          wr = (md != 2'b10) || !me || mb;
    if (md == 2'b00) d = old;
    else begin
      d = '0;
      d[127:64] = s1[127:64];
    end
    d[63:0] = wr ? c[63:0] : (zm ? 64'b0 : old[63:0]);
    return {wr & c[65], wr & c[64], d};
  endfunction

  task automatic check(string req, logic [VW+1:0] act, logic [VW+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offer one operation, let it be taken, check at the following negedge.
  task automatic run_op(string req, logic [1:0] md, logic me, logic mb,
      logic zm, logic [VW-1:0] old, logic [VW-1:0] s1, logic [31:0] x);
    @(negedge clk);
    mode = md; mask_en = me; mask_bit = mb; zero_mask = zm;
    dst_old = old; src1 = s1; cvt_src = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, flag_invalid, flag_denorm, out_data},
          {1'b1, expect_out(md, me, mb, zm, old, s1, x)});
  endtask

  task automatic t_reset();
    check("R10 reset", {out_valid, flag_invalid, flag_denorm, out_data}, '0);
  endtask

  task automatic t_normal();
    run_op("R1 one", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h3F80_0000);
    run_op("R1 neg", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'hC020_0000);
    run_op("R1 max", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h7F7F_FFFF);
    run_op("R1 minnorm", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h0080_0000);
    run_op("R1 odd", 2'b10, 0, 0, 0, OLD_V, S1_V, 32'h4049_0FDB);
  endtask

  task automatic t_denorm();
    run_op("R2 least", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h0000_0001);
    run_op("R2 largest", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h007F_FFFF);
    run_op("R2 neg", 2'b10, 0, 0, 0, OLD_V, S1_V, 32'h8040_0000);
    run_op("R2 mid", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h0001_2345);
  endtask

  task automatic t_nan();
    run_op("R3 snan", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h7F80_0001);
    run_op("R3 snan neg", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'hFFA5_5555);
    run_op("R3 qnan", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'hFFC0_0000);
    run_op("R3 qnan payload", 2'b00, 0, 0, 0, OLD_V, S1_V, 32'h7FE0_1234);
  endtask

  task automatic t_zero_inf();
    run_op("R4 +0", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h0000_0000);
    run_op("R4 -0", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h8000_0000);
    run_op("R4 +inf", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'h7F80_0000);
    run_op("R4 -inf", 2'b01, 0, 0, 0, OLD_V, S1_V, 32'hFF80_0000);
  endtask

  task automatic t_modes();
    run_op("R5 legacy", 2'b00, 0, 0, 0, OLD_V, S1_V, 32'h3F80_0000);
    run_op("R5 legacy denorm", 2'b00, 0, 0, 0, ~OLD_V, S1_V, 32'h0000_0010);
    run_op("R6 evex upper", 2'b10, 0, 0, 0, OLD_V, ~S1_V, 32'h4120_0000);
    run_op("R6 spare as vex", 2'b11, 1, 0, 1, OLD_V, S1_V, 32'h4120_0000);
  endtask

  task automatic t_mask();
    run_op("R7 merge", 2'b10, 1, 0, 0, OLD_V, S1_V, 32'h7F80_0001);
    run_op("R7 zero", 2'b10, 1, 0, 1, OLD_V, S1_V, 32'h0000_0001);
    run_op("R7 bit set", 2'b10, 1, 1, 1, OLD_V, S1_V, 32'h7F80_0001);
    run_op("R7 no mask", 2'b10, 0, 0, 1, OLD_V, S1_V, 32'h0000_0003);
  endtask

  task automatic t_ignore();
    run_op("R8 vex masked", 2'b01, 1, 0, 1, OLD_V, S1_V, 32'h7F80_0001);
    run_op("R8 legacy masked", 2'b00, 1, 0, 0, OLD_V, S1_V, 32'h0000_0001);
  endtask

  task automatic t_stall();
    logic [VW+1:0] first;
    @(negedge clk);
    out_ready = 1'b0;
    mode = 2'b01; mask_en = 0; mask_bit = 0; zero_mask = 0;
    dst_old = OLD_V; src1 = S1_V; cvt_src = 32'h7F80_0002; in_valid = 1'b1;
    first = expect_out(2'b01, 0, 0, 0, OLD_V, S1_V, 32'h7F80_0002);
    @(negedge clk);
    check("R9 first", {out_valid, flag_invalid, flag_denorm, out_data},
          {1'b1, first});
    cvt_src = 32'h0000_0007; mode = 2'b00;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 held", {in_ready, out_valid, flag_invalid, flag_denorm, out_data},
            {2'b01, first});
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next", {out_valid, flag_invalid, flag_denorm, out_data},
          {1'b1, expect_out(2'b00, 0, 0, 0, OLD_V, S1_V, 32'h0000_0007)});
    @(negedge clk);
    check("R9 drain", {63'b0, out_valid}, 64'b0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_denorm();
    t_nan();
    t_zero_inf();
    t_modes();
    t_mask();
    t_ignore();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule